// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Pair

This block sits behind a CAN receiver's frame assembly stage. When a complete frame is offered (identifier, frame-type flag, length code and payload, qualified by a one-cycle strobe), the block compares the identifier against six programmable filters. Filters 0 and 1 share the first mask and feed receive slot 0. Filters 2 to 5 share the second mask and feed receive slot 1. A frame that passes is copied into its slot together with the index of the filter that caught it. A frame that fails is dropped.

Each slot has a full flag that the block sets on load and the CPU clears to release the slot. A frame accepted for an occupied slot is discarded and reported as an overrun. An optional double-buffer mode lets slot 0 spill into slot 1. Error pulses from the bit-level logic drive a saturating receive error counter with a warning level. A small write-only register port loads filters, masks and control bits and clears flags. The slot contents and all flags leave the block as plain outputs.

A three-state sequencer handles each frame. The states are IDLE, MATCH and LOAD. IDLE moves to MATCH when the strobe is seen, and the frame is captured. MATCH always moves to LOAD, and the filter verdicts are registered. LOAD always moves back to IDLE, and the slot write or overrun is committed.

Top module: `can_rx_accept`

## Requirements
- R1: After reset, both full flags, both overrun flags, the error flag, the warning flag, the error count and `irq` are all 0.
- R2: Slot 0 is checked first, against filters 0 and 1 under mask 0. Slot 1 is checked only if slot 0 rejects, against filters 2 to 5 under mask 1. The stored hit index is the lowest-numbered matching filter of that slot. In receive mode 11 it is 7.
- R3: An identifier bit whose mask bit is 0 always matches. A standard frame (`frm_ide`=0) compares identifier bits [10:0] only. An extended frame compares bits [28:0].
- R4: Each slot has a 2-bit receive mode. 00 uses only filters whose type bit equals `frm_ide`. 01 accepts only extended frames and ignores the filter type bit. 10 accepts only standard frames and ignores the filter type bit. 11 accepts every frame without filtering.
- R5: A frame rejected by both slots changes no slot content and no flag.
- R6: On a load, the slot's identifier, type, length, data and hit index are written in the same clock edge as the full flag is set. That edge is the second rising edge after the edge that sampled `frm_valid`.
- R7: A frame accepted for a full slot is discarded with double-buffering off. The slot keeps its old content, and that slot's overrun flag and the error flag are set.
- R8: With double-buffering on, a frame for a full slot 0 loads slot 1 if slot 1 is empty, and no slot 0 overrun is raised. If both slots are full, the frame is lost and the slot 1 overrun and error flags are set.
- R9: Register map, written with `wr_en`. Addresses 0 to 5 are filters: bits [28:0] are the identifier and bit 29 is the type bit. Addresses 6 and 7 are masks 0 and 1, in bits [28:0]. Address 8 is control: [1:0] mode 0, [3:2] mode 1, [4] double-buffer, [5] slot 0 interrupt enable, [6] slot 1 interrupt enable, [7] warning interrupt enable. Address 9 is write-one-to-clear: [0] full 0, [1] full 1, [2] overrun 0, [3] overrun 1, [4] error flag.
- R10: `irq` is high while any of these holds: full 0 with its enable set, full 1 with its enable set, or warning with its enable set.
- R11: Each `rx_err` pulse adds one to the error count, which saturates at 255. The warning flag is 1 once the count is 96 or more.
- R12: A strobe seen while the sequencer is in MATCH or LOAD is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Assembled frame strobe |
| frm_ide | input | 1 | 1 = extended frame |
| frm_id | input | 29 | Identifier (standard in [10:0]) |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload |
| rx_err | input | 1 | One receive error event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 30 | Register write data |
| b0_full | output | 1 | Slot 0 holds an unread frame |
| b1_full | output | 1 | Slot 1 holds an unread frame |
| b0_ovr | output | 1 | Slot 0 overrun |
| b1_ovr | output | 1 | Slot 1 overrun |
| err_flag | output | 1 | General error flag |
| warn_flag | output | 1 | Error count at warning level |
| err_cnt | output | 8 | Receive error count |
| irq | output | 1 | Combined receive interrupt |
| b0_id | output | 29 | Slot 0 identifier |
| b0_ide | output | 1 | Slot 0 frame type |
| b0_dlc | output | 4 | Slot 0 length code |
| b0_data | output | 64 | Slot 0 payload |
| b0_hit | output | 3 | Slot 0 filter index |
| b1_id | output | 29 | Slot 1 identifier |
| b1_ide | output | 1 | Slot 1 frame type |
| b1_dlc | output | 4 | Slot 1 length code |
| b1_data | output | 64 | Slot 1 payload |
| b1_hit | output | 3 | Slot 1 filter index |

## Verification
A frame result is due at the second rising edge after the edge that samples the strobe. The bench drives each frame on a falling edge, waits through three rising edges and samples on the following falling edge. Register writes, flag clears and error pulses take effect at the rising edge that samples them. Their outputs, including `irq` and the warning flag, are checked on the next falling edge. Random frames are spaced at least four cycles apart, so that only the ignore test deliberately lands a strobe in MATCH.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int HIT_W  = 3;

    typedef enum logic [1:0] {S_IDLE, S_MATCH, S_LOAD} acc_state_e;

    typedef enum logic [1:0] {
        M_TYPED = 2'b00,
        M_EXT   = 2'b01,
        M_STD   = 2'b10,
        M_ALL   = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic              ide;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/can_rx_filt.sv
module can_rx_filt
    import can_rx_pkg::*;
(
    input  logic [ID_W-1:0] f_id,
    input  logic            f_ext,
    input  logic [ID_W-1:0] mask,
    input  logic [1:0]      mode,
    input  logic            ide,
    input  logic [ID_W-1:0] id,
    output logic            hit
);
    localparam logic [ID_W-1:0] STD_MASK = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

    logic [ID_W-1:0] width_mask;
    logic            bits_ok;
    logic            type_ok;

    always_comb begin
        width_mask = ide ? {ID_W{1'b1}} : STD_MASK;
        bits_ok    = (((id ^ f_id) & mask & width_mask) == '0);
        unique case (mode)
            M_TYPED: type_ok = (f_ext == ide);
            M_EXT:   type_ok = ide;
            M_STD:   type_ok = !ide;
            M_ALL:   type_ok = 1'b0;
            default: type_ok = 1'b0;
        endcase
        hit = type_ok && bits_ok;
    end
endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot
    import can_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             release_i,
    input  frame_t           frm_in,
    input  logic [HIT_W-1:0] hit_in,
    output frame_t           frm_q,
    output logic [HIT_W-1:0] hit_q,
    output logic             full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
            hit_q <= '0;
            full  <= 1'b0;
        end else if (load) begin
            frm_q <= frm_in;
            hit_q <= hit_in;
            full  <= 1'b1;
        end else if (release_i) begin
            full  <= 1'b0;
        end
    end
endmodule

// File: rtl/can_rx_errcnt.sv
module can_rx_errcnt #(
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    output logic [CNT_W-1:0] cnt,
    output logic             warn
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM     = CNT_W'(WARN_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (err_pulse && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign warn = (cnt >= LIM);
endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
    import can_rx_pkg::*;
#(
    parameter int N_FILT   = 6,
    parameter int N_B0     = 2,
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ide,
    input  logic [28:0]       frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              rx_err,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [29:0]       wr_data,
    output logic              b0_full,
    output logic              b1_full,
    output logic              b0_ovr,
    output logic              b1_ovr,
    output logic              err_flag,
    output logic              warn_flag,
    output logic [CNT_W-1:0]  err_cnt,
    output logic              irq,
    output logic [28:0]       b0_id,
    output logic              b0_ide,
    output logic [3:0]        b0_dlc,
    output logic [63:0]       b0_data,
    output logic [2:0]        b0_hit,
    output logic [28:0]       b1_id,
    output logic              b1_ide,
    output logic [3:0]        b1_dlc,
    output logic [63:0]       b1_data,
    output logic [2:0]        b1_hit
);
    localparam logic [ADDR_W-1:0] A_MASK0 = ADDR_W'(N_FILT);
    localparam logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(N_FILT + 1);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(N_FILT + 2);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(N_FILT + 3);
    localparam logic [HIT_W-1:0]  HIT_ALL = {HIT_W{1'b1}};

    // configuration
    logic [ID_W-1:0]   f_id [N_FILT];
    logic [N_FILT-1:0] f_ext;
    logic [ID_W-1:0]   msk [2];
    logic [1:0]        mode0, mode1;
    logic              ctl_dben, ctl_ie0, ctl_ie1, ctl_wie;
    logic              clr_wr;

    assign clr_wr = wr_en && (wr_addr == A_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_FILT; i++) f_id[i] <= '0;
            f_ext    <= '0;
            msk[0]   <= '0;
            msk[1]   <= '0;
            mode0    <= M_TYPED;
            mode1    <= M_TYPED;
            ctl_dben <= 1'b0;
            ctl_ie0  <= 1'b0;
            ctl_ie1  <= 1'b0;
            ctl_wie  <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < N_FILT; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    f_id[i]  <= wr_data[ID_W-1:0];
                    f_ext[i] <= wr_data[ID_W];
                end
            end
            if (wr_addr == A_MASK0) msk[0] <= wr_data[ID_W-1:0];
            if (wr_addr == A_MASK1) msk[1] <= wr_data[ID_W-1:0];
            if (wr_addr == A_CTRL) begin
                mode0    <= wr_data[1:0];
                mode1    <= wr_data[3:2];
                ctl_dben <= wr_data[4];
                ctl_ie0  <= wr_data[5];
                ctl_ie1  <= wr_data[6];
                ctl_wie  <= wr_data[7];
            end
        end
    end

    // sequencer
    acc_state_e st, st_nx;
    frame_t     cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            S_IDLE:  st_nx = frm_valid ? S_MATCH : S_IDLE;
            S_MATCH: st_nx = S_LOAD;
            S_LOAD:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap <= '0;
        else if (st == S_IDLE && frm_valid)
            cap <= '{ide: frm_ide, id: frm_id, dlc: frm_dlc, data: frm_data};
    end

    // filter slices
    logic [N_FILT-1:0] hits;

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        can_rx_filt u_filt (
            .f_id  (f_id[g]),
            .f_ext (f_ext[g]),
            .mask  ((g < N_B0) ? msk[0] : msk[1]),
            .mode  ((g < N_B0) ? mode0 : mode1),
            .ide   (cap.ide),
            .id    (cap.id),
            .hit   (hits[g])
        );
    end

    logic             any0, any1;
    logic [HIT_W-1:0] idx0, idx1;

    always_comb begin
        any0 = 1'b0;
        any1 = 1'b0;
        idx0 = '0;
        idx1 = '0;
        for (int i = N_FILT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                if (i < N_B0) begin
                    any0 = 1'b1;
                    idx0 = HIT_W'(i);
                end else begin
                    any1 = 1'b1;
                    idx1 = HIT_W'(i);
                end
            end
        end
    end

    // verdicts registered in MATCH
    logic             acc0, acc1;
    logic [HIT_W-1:0] hit0, hit1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc0 <= 1'b0;
            acc1 <= 1'b0;
            hit0 <= '0;
            hit1 <= '0;
        end else if (st == S_MATCH) begin
            acc0 <= (mode0 == M_ALL) || any0;
            acc1 <= (mode1 == M_ALL) || any1;
            hit0 <= (mode0 == M_ALL) ? HIT_ALL : idx0;
            hit1 <= (mode1 == M_ALL) ? HIT_ALL : idx1;
        end
    end

    // commit decisions in LOAD
    logic             ld0, ld1, roll, set_ovr0, set_ovr1;
    logic [HIT_W-1:0] hit_b1;

    always_comb begin
        ld0      = 1'b0;
        ld1      = 1'b0;
        roll     = 1'b0;
        set_ovr0 = 1'b0;
        set_ovr1 = 1'b0;
        if (st == S_LOAD) begin
            if (acc0) begin
                if (!b0_full)      ld0 = 1'b1;
                else if (!ctl_dben) set_ovr0 = 1'b1;
                else if (!b1_full) roll = 1'b1;
                else               set_ovr1 = 1'b1;
            end else if (acc1) begin
                if (!b1_full) ld1 = 1'b1;
                else          set_ovr1 = 1'b1;
            end
        end
        hit_b1 = roll ? hit0 : hit1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b0_ovr   <= 1'b0;
            b1_ovr   <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            b0_ovr   <= set_ovr0 || (b0_ovr && !(clr_wr && wr_data[2]));
            b1_ovr   <= set_ovr1 || (b1_ovr && !(clr_wr && wr_data[3]));
            err_flag <= set_ovr0 || set_ovr1 || (err_flag && !(clr_wr && wr_data[4]));
        end
    end

    frame_t s0, s1;

    can_rx_slot u_slot0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld0),
        .release_i (clr_wr && wr_data[0]),
        .frm_in    (cap),
        .hit_in    (hit0),
        .frm_q     (s0),
        .hit_q     (b0_hit),
        .full      (b0_full)
    );

    can_rx_slot u_slot1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld1 || roll),
        .release_i (clr_wr && wr_data[1]),
        .frm_in    (cap),
        .hit_in    (hit_b1),
        .frm_q     (s1),
        .hit_q     (b1_hit),
        .full      (b1_full)
    );

    can_rx_errcnt #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM)) u_errcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (rx_err),
        .cnt       (err_cnt),
        .warn      (warn_flag)
    );

    assign {b0_ide, b0_id, b0_dlc, b0_data} = s0;
    assign {b1_ide, b1_id, b1_dlc, b1_data} = s1;
    assign irq = (b0_full && ctl_ie0) || (b1_full && ctl_ie1) || (warn_flag && ctl_wie);
endmodule

// File: rtl/can_rx_accept_chk.sv
module can_rx_accept_chk
    import can_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input acc_state_e st,
    input logic       b0_full,
    input logic       b1_full,
    input logic       b0_ovr,
    input logic       b1_ovr,
    input logic       dben,
    input logic       ie1,
    input logic       irq,
    input logic [7:0] err_cnt,
    input logic [28:0] b0_id
);
    a_r7_ovr0_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b0_ovr) |-> $past(b0_full));

    a_r7_ovr1_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b1_ovr) |-> $past(b1_full));

    a_r8_no_ovr0_when_double: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b0_ovr) |-> !$past(dben));

    a_r6_full0_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b0_full) |-> ($past(st) == S_LOAD));

    a_r6_full1_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b1_full) |-> ($past(st) == S_LOAD));

    a_r7_slot0_held: assert property (@(posedge clk) disable iff (!rst_n)
        (b0_full && $past(b0_full)) |-> $stable(b0_id));

    a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 8'd1));

    a_r10_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(b1_full) && ie1) |-> irq);

    a_r12_match_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MATCH) |=> (st == S_LOAD));
endmodule

bind can_rx_accept can_rx_accept_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .b0_full (b0_full),
    .b1_full (b1_full),
    .b0_ovr  (b0_ovr),
    .b1_ovr  (b1_ovr),
    .dben    (ctl_dben),
    .ie1     (ctl_ie1),
    .irq     (irq),
    .err_cnt (err_cnt),
    .b0_id   (b0_id)
);

// File: tb/can_rx_accept_tb.sv
module can_rx_accept_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_ide = 1'b0, rx_err = 1'b0, wr_en = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0, wr_addr = '0;
    logic [63:0] frm_data = '0;
    logic [29:0] wr_data = '0;
    logic        b0_full, b1_full, b0_ovr, b1_ovr, err_flag, warn_flag, irq, b0_ide, b1_ide;
    logic [7:0]  err_cnt;
    logic [28:0] b0_id, b1_id;
    logic [3:0]  b0_dlc, b1_dlc;
    logic [63:0] b0_data, b1_data;
    logic [2:0]  b0_hit, b1_hit;

    int n_chk = 0, n_bad = 0;

    can_rx_accept u_dut (.*);

    always #10 clk = ~clk;

    // model state
    logic [28:0] m_fid [6];
    logic [5:0]  m_fext;
    logic [28:0] m_msk [2];
    logic [1:0]  m_mode [2];
    logic        m_dben, m_ie0, m_ie1, m_wie;
    logic        e_full [2], e_ovr [2], e_err, e_ide [2];
    logic [28:0] e_id [2];
    logic [3:0]  e_dlc [2];
    logic [63:0] e_data [2];
    logic [2:0]  e_hit [2];
    int          e_cnt = 0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bmatch(int b, logic ide, logic [28:0] id);
        logic [28:0] wm;
        int lo, hi;
        wm = ide ? 29'h1FFF_FFFF : 29'h7FF;
        lo = b ? 2 : 0;
        hi = b ? 5 : 1;
        if (m_mode[b] == 2'b11) return 7;
        if (m_mode[b] == 2'b01 && !ide) return -1;
        if (m_mode[b] == 2'b10 && ide) return -1;
        for (int i = lo; i <= hi; i++)
            if ((m_mode[b] != 2'b00 || m_fext[i] == ide) && (((id ^ m_fid[i]) & m_msk[b] & wm) == 0))
                return i;
        return -1;
    endfunction

    function automatic logic exp_irq();
        return (e_full[0] && m_ie0) || (e_full[1] && m_ie1) || (e_cnt >= 96 && m_wie);
    endfunction

    task automatic wr(logic [3:0] a, logic [29:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 6) begin m_fid[a] = d[28:0]; m_fext[a] = d[29]; end
        else if (a == 6) m_msk[0] = d[28:0];
        else if (a == 7) m_msk[1] = d[28:0];
        else if (a == 8) begin
            m_mode[0] = d[1:0]; m_mode[1] = d[3:2];
            m_dben = d[4]; m_ie0 = d[5]; m_ie1 = d[6]; m_wie = d[7];
        end else if (a == 9) begin
            if (d[0]) e_full[0] = 1'b0;
            if (d[1]) e_full[1] = 1'b0;
            if (d[2]) e_ovr[0] = 1'b0;
            if (d[3]) e_ovr[1] = 1'b0;
            if (d[4]) e_err = 1'b0;
        end
    endtask

    task automatic mload(int b, int h);
        e_full[b] = 1'b1; e_id[b] = frm_id; e_ide[b] = frm_ide;
        e_dlc[b] = frm_dlc; e_data[b] = frm_data; e_hit[b] = h[2:0];
    endtask

    task automatic compare_all(string req);
        check(req, "b0_full", 64'(b0_full), 64'(e_full[0]));
        check(req, "b1_full", 64'(b1_full), 64'(e_full[1]));
        check(req, "b0_ovr", 64'(b0_ovr), 64'(e_ovr[0]));
        check(req, "b1_ovr", 64'(b1_ovr), 64'(e_ovr[1]));
        check(req, "err_flag", 64'(err_flag), 64'(e_err));
        check("R10", "irq", 64'(irq), 64'(exp_irq()));
        if (e_full[0]) begin
            check(req, "b0_id", 64'(b0_id), 64'(e_id[0]));
            check(req, "b0_meta", {b0_ide, b0_dlc, b0_hit}, {e_ide[0], e_dlc[0], e_hit[0]});
            check(req, "b0_data", b0_data, e_data[0]);
        end
        if (e_full[1]) begin
            check(req, "b1_id", 64'(b1_id), 64'(e_id[1]));
            check(req, "b1_meta", {b1_ide, b1_dlc, b1_hit}, {e_ide[1], e_dlc[1], e_hit[1]});
            check(req, "b1_data", b1_data, e_data[1]);
        end
    endtask

    // drive one frame, update model, check at the R6 result cycle
    task automatic send(logic ide, logic [28:0] id, int hold, output string req);
        int h0, h1;
        @(negedge clk);
        frm_valid = 1'b1; frm_ide = ide; frm_id = id;
        frm_dlc = 4'($urandom); frm_data = {$urandom, $urandom};
        h0 = bmatch(0, ide, id);
        h1 = bmatch(1, ide, id);
        if (h0 >= 0) begin
            if (!e_full[0]) begin mload(0, h0); req = "R2"; end
            else if (!m_dben) begin e_ovr[0] = 1'b1; e_err = 1'b1; req = "R7"; end
            else if (!e_full[1]) begin mload(1, h0); req = "R8"; end
            else begin e_ovr[1] = 1'b1; e_err = 1'b1; req = "R8"; end
        end else if (h1 >= 0) begin
            if (!e_full[1]) begin mload(1, h1); req = "R2"; end
            else begin e_ovr[1] = 1'b1; e_err = 1'b1; req = "R7"; end
        end else req = "R5";
        @(posedge clk);
        if (hold > 1) begin
            @(negedge clk);
            frm_id = ~id; frm_ide = ~ide;
            @(posedge clk);
        end
        @(negedge clk);
        frm_valid = 1'b0;
        if (hold <= 1) @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic err_pulse();
        @(negedge clk);
        rx_err = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_err = 1'b0;
        if (e_cnt < 255) e_cnt++;
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string rq;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_fid[i] = '0;
        m_fext = '0; m_msk[0] = '0; m_msk[1] = '0; m_mode[0] = 0; m_mode[1] = 0;
        m_dben = 0; m_ie0 = 0; m_ie1 = 0; m_wie = 0;
        for (int b = 0; b < 2; b++) begin e_full[b] = 0; e_ovr[b] = 0; end
        e_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "flags", {b0_full, b1_full, b0_ovr, b1_ovr, err_flag, warn_flag, irq}, 0);
        check("R1", "err_cnt", 64'(err_cnt), 0);

        // R3: standard frame ignores upper bits and mask-zero bits
        wr(0, {1'b0, 29'h123});
        wr(1, {1'b0, 29'h1FFF_FFFF});
        wr(6, 30'h1FFF_FFFE);
        wr(7, 30'h1FFF_FFFF);
        for (int i = 2; i < 6; i++) wr(4'(i), {1'b1, 29'h0AAA_AAAA});
        wr(8, 30'h20);
        send(1'b0, 29'h1010_0122, 1, rq);
        check("R3", "b0_hit", 64'(b0_hit), 0);
        compare_all("R3");
        check("R10", "irq_set", 64'(irq), 1);
        wr(9, 30'h1);
        check("R9", "release", 64'(b0_full), 0);

        // R4: mode 01 accepts extended frame despite filter type bit 0
        wr(8, 30'h01);
        send(1'b1, 29'h0000_0123, 1, rq);
        check("R4", "ext_accept", 64'(b0_full), 1);
        compare_all("R4");
        wr(9, 30'h1);
        // R4: mode 10 rejects extended frame; slot 1 filters don't match
        wr(8, 30'h02);
        send(1'b1, 29'h0000_0123, 1, rq);
        check("R4", "std_only", 64'(b0_full), 0);
        compare_all("R5");

        // R12: strobe held into MATCH is ignored
        wr(8, 30'h03);
        send(1'b0, 29'h0000_0055, 2, rq);
        check("R12", "first_kept", 64'(b0_id), 64'(29'h55));
        check("R12", "no_second", {b1_full, b0_ovr}, 0);
        compare_all("R12");

        // R7 then R8 directed overrun
        send(1'b1, 29'h0123_4567, 1, rq);
        check("R7", "ovr0", {b0_ovr, err_flag}, 2'b11);
        check("R7", "kept", 64'(b0_id), 64'(29'h55));
        wr(9, 30'h1C);
        wr(8, 30'h13);
        send(1'b1, 29'h0123_4567, 1, rq);
        check("R8", "roll", {b1_full, b0_ovr, b1_hit}, {1'b1, 1'b0, 3'd7});
        send(1'b0, 29'h0000_0001, 1, rq);
        check("R8", "ovr1", {b1_ovr, b0_ovr, err_flag}, 3'b101);
        compare_all("R8");
        wr(9, 30'h1F);

        // random phase
        for (int it = 0; it < 600; it++) begin
            if (it % 50 == 0) begin
                for (int i = 0; i < 6; i++) wr(4'(i), 30'($urandom));
                wr(6, 30'(~($urandom & $urandom & $urandom)));
                wr(7, 30'(~($urandom & $urandom & $urandom)));
                wr(8, {22'd0, 4'($urandom), ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom & 32'h5)});
            end
            if ($urandom % 2 == 0) begin
                wr(9, 30'($urandom % 32));
                compare_all("R9");
            end
            begin
                int k = $urandom % 6;
                logic ide = ($urandom % 5 == 0) ? 1'($urandom) : m_fext[k];
                logic [28:0] id = m_fid[k] ^ (29'($urandom) & ~m_msk[k < 2 ? 0 : 1]);
                if ($urandom % 4 == 0) id = 29'($urandom);
                send(ide, id, 1, rq);
                compare_all(rq);
            end
        end

        // R11 error counter
        for (int i = 0; i < 300; i++) begin
            err_pulse();
            if (e_cnt == 95 || e_cnt == 96)
                check("R11", "warn", 64'(warn_flag), 64'(e_cnt >= 96));
        end
        check("R11", "saturate", 64'(err_cnt), 255);
        wr(8, 30'h80);
        check("R10", "warn_irq", 64'(irq), 64'(exp_irq()));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule